// File: doc/BRIEF.md
# Presettable Synchronous Counter with Dual Count Enables

This block is a four-bit synchronous counter that a parameter builds either as a modulus-16 binary counter or as a modulus-10 decade counter. Its state register moves on the rising clock edge. It can be zeroed at any moment by an active-low clear that does not wait for the clock. An active-low load captures a parallel word on the clock edge.

Counting requires two enables, a count enable and a carry enable, to be high together. The terminal-count output is gated by the carry enable. Several copies can therefore be chained into a wider counter: each stage's terminal-count output drives the carry enable of the next stage, and all stages share one clock.

Each clock edge applies one of three named actions, chosen in priority order. ACT_LOAD is chosen when load is low. ACT_STEP is chosen when load is high and both enables are high. ACT_HOLD covers every other case. The asynchronous clear overrides all three.

The state transitions are as follows:
- STEP_INC moves the state to state + 1.
- STEP_WRAP moves the state from the terminal count to 0.
- STEP_RECOVER applies in decade mode only. It moves any state from 10 to 15 to 0.
- LOAD_COPY sets the state to the parallel word.
- HOLD_KEEP leaves the state unchanged.
- CLEAR_ZERO forces the state to 0 asynchronously.

Top module: `sync_preset_counter`

## Requirements
- R1: With clr_n high, load_n high and both cnt_en and carry_en high, q increases by exactly one on each rising clock edge.
- R2: While clr_n is low, q is 0 without waiting for a clock edge. Clear takes precedence over load and over counting.
- R3: With clr_n high and load_n low, q takes the value of par_in at the next rising edge, whatever cnt_en and carry_en are.
- R4: While load_n is high, the value of par_in has no effect on q.
- R5: With clr_n high, load_n high and either cnt_en or carry_en low, q keeps its value across the clock edge.
- R6: tc_carry is 1 exactly when q equals the terminal count and carry_en is high. The terminal count is 15 in binary mode (DECADE=0).
- R7: In decade mode (DECADE=1), counting runs 0,1,…,9,0. The terminal count is 9, so tc_carry is 1 at q=9 when carry_en is high.
- R8: In decade mode, a state from 10 to 15, reached by loading, moves to 0 on the next counting edge. tc_carry stays 0 while q is in that range.
- R9: In binary mode, counting from 15 wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state changes on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Count enable |
| carry_en | input | 1 | Count enable that also gates tc_carry |
| par_in | input | W | Parallel load word |
| q | output | W | Counter state |
| tc_carry | output | 1 | Terminal count gated by carry_en |

## Verification
The bench builds two copies of the block and drives both with the same stimulus: one with DECADE=0 and one with DECADE=1, each at the default width of 4. The DECADE=0 copy exercises the 15-to-0 wrap and carry at 15. The DECADE=1 copy exercises the 9-to-0 wrap, carry at 9, and the recovery from states 10 to 15 after a load. Because both copies see the same inputs, the bench can compare how the two modes respond to one sequence. That sequence includes loads that arrive with counting enabled and a clear that arrives between clock edges.

// File: rtl/sync_preset_counter_pkg.sv
package sync_preset_counter_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_STEP = 2'd2
    } act_e;

    // Terminal count for a given width and mode
    function automatic int unsigned term_count(input int unsigned w, input bit decade);
        return decade ? 32'd9 : ((32'd1 << w) - 32'd1);
    endfunction

endpackage

// File: rtl/cnt_action_sel.sv
module cnt_action_sel
    import sync_preset_counter_pkg::*;
(
    input  logic load_n,
    input  logic cnt_en,
    input  logic carry_en,
    output act_e act
);
    // Load beats counting; counting needs both enables.
    always_comb begin
        if (!load_n)
            act = ACT_LOAD;
        else if (cnt_en && carry_en)
            act = ACT_STEP;
        else
            act = ACT_HOLD;
    end
endmodule

// File: rtl/cnt_step_logic.sv
module cnt_step_logic #(
    parameter int unsigned W      = 4,
    parameter bit          DECADE = 1'b0
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);
    localparam int unsigned TERM   = sync_preset_counter_pkg::term_count(W, DECADE);
    localparam logic [W-1:0] TERM_V = W'(TERM);

    generate
        if (DECADE) begin : g_decade
            // Terminal count and every unused code above it return to zero.
            always_comb begin
                if (cur >= TERM_V)
                    nxt = '0;
                else
                    nxt = cur + 1'b1;
            end
        end else begin : g_binary
            always_comb nxt = cur + 1'b1;
        end
    endgenerate
endmodule

// File: rtl/cnt_tc_decode.sv
module cnt_tc_decode #(
    parameter int unsigned W      = 4,
    parameter bit          DECADE = 1'b0
) (
    input  logic [W-1:0] cur,
    output logic         at_term
);
    localparam int unsigned  TERM   = sync_preset_counter_pkg::term_count(W, DECADE);
    localparam logic [W-1:0] TERM_V = W'(TERM);

    always_comb at_term = (cur == TERM_V);
endmodule

// File: rtl/sync_preset_counter.sv
module sync_preset_counter
    import sync_preset_counter_pkg::*;
#(
    parameter int unsigned W      = 4,
    parameter bit          DECADE = 1'b0
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         load_n,
    input  logic         cnt_en,
    input  logic         carry_en,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] q,
    output logic         tc_carry
);
    act_e         act;
    logic [W-1:0] step_val;
    logic         at_term;

    cnt_action_sel u_sel (
        .load_n   (load_n),
        .cnt_en   (cnt_en),
        .carry_en (carry_en),
        .act      (act)
    );

    cnt_step_logic #(.W(W), .DECADE(DECADE)) u_step (
        .cur (q),
        .nxt (step_val)
    );

    cnt_tc_decode #(.W(W), .DECADE(DECADE)) u_tc (
        .cur     (q),
        .at_term (at_term)
    );

    // State register: asynchronous clear, then the selected action
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            q <= '0;
        end else begin
            unique case (act)
                ACT_LOAD: q <= par_in;
                ACT_STEP: q <= step_val;
                ACT_HOLD: q <= q;
                default:  q <= q;
            endcase
        end
    end

    // Output: terminal count gated by the carry enable
    always_comb tc_carry = at_term && carry_en;
endmodule

// File: rtl/sync_preset_counter_chk.sv
module sync_preset_counter_chk #(
    parameter int unsigned W      = 4,
    parameter bit          DECADE = 1'b0
) (
    input logic         clk,
    input logic         clr_n,
    input logic         load_n,
    input logic         cnt_en,
    input logic         carry_en,
    input logic [W-1:0] par_in,
    input logic [W-1:0] q,
    input logic         tc_carry
);
    localparam logic [W-1:0] TERM_V = W'(sync_preset_counter_pkg::term_count(W, DECADE));

    // R1 and R9: a counting edge below the terminal count adds one
    p_count_step_r1: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && cnt_en && carry_en && q < TERM_V) |=> (q == $past(q) + 1'b1));

    // R7 and R9: a counting edge at the terminal count returns to zero
    p_wrap_r7: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && cnt_en && carry_en && q == TERM_V) |=> (q == '0));

    // R2: clear low at a clock edge means the state reads zero
    p_clear_zero_r2: assert property (@(posedge clk)
        !clr_n |-> (q == '0));

    // R3: a load captures the parallel word whatever the enables are
    p_load_copy_r3: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> (q == $past(par_in)));

    // R5: either enable low holds the state
    p_hold_r5: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(cnt_en && carry_en)) |=> $stable(q));

    // R6: the carry output never rises without the carry enable
    p_carry_gate_r6: assert property (@(posedge clk) disable iff (!clr_n)
        tc_carry |-> (carry_en && q == TERM_V));

    generate
        if (DECADE) begin : g_dec_chk
            // R8: a counting edge from an unused code returns to zero
            p_recover_r8: assert property (@(posedge clk) disable iff (!clr_n)
                (load_n && cnt_en && carry_en && q > TERM_V) |=> (q == '0));
        end
    endgenerate
endmodule

bind sync_preset_counter sync_preset_counter_chk #(.W(W), .DECADE(DECADE)) chk_i (
    .clk      (clk),
    .clr_n    (clr_n),
    .load_n   (load_n),
    .cnt_en   (cnt_en),
    .carry_en (carry_en),
    .par_in   (par_in),
    .q        (q),
    .tc_carry (tc_carry)
);

// File: tb/sync_preset_counter_tb_top.sv
module sync_preset_counter_tb_top;
    logic       clk = 1'b0;
    logic       clr_n, load_n, cnt_en, carry_en;
    logic [3:0] par_in;
    logic [3:0] qb, qd;
    logic       cb, cd;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done  = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    sync_preset_counter #(.W(4), .DECADE(1'b0)) dut_i (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
        .carry_en(carry_en), .par_in(par_in), .q(qb), .tc_carry(cb));

    sync_preset_counter #(.W(4), .DECADE(1'b1)) dut_dec_i (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
        .carry_en(carry_en), .par_in(par_in), .q(qd), .tc_carry(cd));

    // Fields: load_n, cnt_en, carry_en, par_in, exp q bin, exp carry bin, exp q dec, exp carry dec
    localparam int NV = 14;
    localparam logic [16:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 4'd7,  4'd7,  1'b0, 4'd7,  1'b0}, // R3 load with enables low
        {1'b1, 1'b1, 1'b1, 4'd3,  4'd8,  1'b0, 4'd8,  1'b0}, // R1 R4 count, par_in ignored
        {1'b1, 1'b1, 1'b1, 4'd3,  4'd9,  1'b0, 4'd9,  1'b1}, // R7 decade carry at 9
        {1'b1, 1'b1, 1'b1, 4'd3,  4'd10, 1'b0, 4'd0,  1'b0}, // R7 decade wraps
        {1'b1, 1'b0, 1'b1, 4'd0,  4'd10, 1'b0, 4'd0,  1'b0}, // R5 cnt_en low
        {1'b1, 1'b1, 1'b0, 4'd0,  4'd10, 1'b0, 4'd0,  1'b0}, // R5 carry_en low
        {1'b0, 1'b0, 1'b1, 4'd14, 4'd14, 1'b0, 4'd14, 1'b0}, // R3 R8 load unused code
        {1'b1, 1'b1, 1'b1, 4'd0,  4'd15, 1'b1, 4'd0,  1'b0}, // R6 R8 bin carry, dec recovers
        {1'b1, 1'b0, 1'b1, 4'd5,  4'd15, 1'b1, 4'd0,  1'b0}, // R4 R5 R6 hold keeps carry
        {1'b1, 1'b0, 1'b0, 4'd5,  4'd15, 1'b0, 4'd0,  1'b0}, // R6 carry gated off
        {1'b1, 1'b1, 1'b1, 4'd0,  4'd0,  1'b0, 4'd1,  1'b0}, // R9 binary wrap
        {1'b0, 1'b1, 1'b1, 4'd9,  4'd9,  1'b0, 4'd9,  1'b1}, // R3 load beats count
        {1'b0, 1'b1, 1'b0, 4'd15, 4'd15, 1'b0, 4'd15, 1'b0}, // R3 R6 load 15, carry gated
        {1'b1, 1'b1, 1'b1, 4'd0,  4'd0,  1'b0, 4'd0,  1'b0}  // R9 R8 both return to zero
    };

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int eb, ed;
        clr_n = 1'b0; load_n = 1'b1; cnt_en = 1'b0; carry_en = 1'b0; par_in = 4'd0;
        repeat (3) @(negedge clk);
        check("R2 reset q bin", qb, 4'd0);
        check("R2 reset q dec", qd, 4'd0);
        check("R6 reset carry bin", {3'b0, cb}, 4'd0);
        check("R7 reset carry dec", {3'b0, cd}, 4'd0);
        clr_n = 1'b1;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            {load_n, cnt_en, carry_en, par_in} = VEC[i][16:10];
            @(negedge clk);
            check($sformatf("vec%0d q bin", i), qb, VEC[i][9:6]);
            check($sformatf("vec%0d carry bin", i), {3'b0, cb}, {3'b0, VEC[i][5]});
            check($sformatf("vec%0d q dec", i), qd, VEC[i][4:1]);
            check($sformatf("vec%0d carry dec", i), {3'b0, cd}, {3'b0, VEC[i][0]});
        end

        // R1 R7 R9: full run from zero, 16 counting edges
        load_n = 1'b1; cnt_en = 1'b1; carry_en = 1'b1; par_in = 4'd11;
        eb = 0; ed = 0;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            eb = (eb + 1) % 16;
            ed = (ed + 1) % 10;
            check("R1 R9 run q bin", qb, 4'(eb));
            check("R6 run carry bin", {3'b0, cb}, (eb == 15) ? 4'd1 : 4'd0);
            check("R7 run q dec", qd, 4'(ed));
            check("R7 run carry dec", {3'b0, cd}, (ed == 9) ? 4'd1 : 4'd0);
        end

        // R8: load 12, then one counting edge
        load_n = 1'b0; par_in = 4'd12;
        @(negedge clk);
        check("R8 loaded q dec", qd, 4'd12);
        check("R8 no carry at 12", {3'b0, cd}, 4'd0);
        load_n = 1'b1;
        @(negedge clk);
        check("R8 recover q dec", qd, 4'd0);
        check("R1 q bin after 12", qb, 4'd13);

        // R2: clear between edges, then clear held across a load edge
        #1 clr_n = 1'b0;
        #0.5;
        check("R2 async clear bin", qb, 4'd0);
        check("R2 async clear dec", qd, 4'd0);
        load_n = 1'b0; par_in = 4'd5;
        @(negedge clk);
        check("R2 clear beats load bin", qb, 4'd0);
        check("R2 clear beats load dec", qd, 4'd0);
        clr_n = 1'b1; load_n = 1'b1; cnt_en = 1'b0; carry_en = 1'b0;
        @(negedge clk);
        check("R5 hold after clear bin", qb, 4'd0);
        check("R5 hold after clear dec", qd, 4'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule